// File: doc/BRIEF.md
# Zeroing tag-store execution unit

This unit carries out a single memory-tagging store that also clears the data it covers. A request supplies a general-purpose base value, a general-purpose source value, the current stack pointer, a 9-bit signed immediate, a 2-bit addressing-mode code, and two flags. One flag chooses the stack pointer as the base. The other chooses it as the tag source. The unit scales the immediate by the 16-byte granule and forms the access address for the selected addressing mode. It then checks alignment.

When the checks pass, the unit writes one granule of zeros through a simple valid/ready memory port. After that write is accepted, it writes the 4-bit allocation tag for the same granule. It then pulses a completion strobe and offers the updated base value for writeback. When a check fails, it pulses completion with a fault code instead and makes no memory access. The store is unchecked: memory tags are never read or compared.

Top module: `tag_zero_store`

## Requirements
- R1: The offset is the 9-bit immediate, sign-extended and shifted left by 4, so it ranges from -4096 to +4080. The written-back value is the base plus that offset, modulo 2^64.
- R2: Mode code 2'b01 is post-index and 2'b11 is pre-index; both write the base back. Code 2'b10 is signed offset and code 2'b00 behaves the same way; neither writes back.
- R3: In pre-index, signed-offset and 2'b00 modes, the access address is base plus offset. In post-index mode it is the unmodified base.
- R4: When reqBaseIsSp is 1, the base comes from reqSp and a writeback raises wbToSp. If reqSp[3:0] is not zero, the request completes with fault code 2'b01. This check takes priority over the granule check.
- R5: If access address bits [3:0] are not zero, and no stack-pointer fault applies, the request completes with fault code 2'b10. No memory write is issued.
- R6: On success, the unit first issues a 128-bit all-zero data write with memDataWr=1 at the access address. It then issues a tag write with memTagWr=1 at the same address. Each write holds memValid until memReady, and the two write strobes are never high together.
- R7: The tag written is bits [59:56] of the tag source. The tag source is reqSp when reqSrcIsSp is 1 and reqGpSrc otherwise.
- R8: reqReady is high only while the unit is idle. doneValid is a one-cycle pulse. It comes after the tag write is accepted, or after a fault is detected. doneFaultCode is 2'b00 on success, and doneFault is high exactly when the code is not zero.
- R9: wbValid is high only together with doneValid, and never together with doneFault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit idle and accepting a request |
| reqGpBase | input | 64 | General-register base value |
| reqGpSrc | input | 64 | General-register tag source value |
| reqSp | input | 64 | Current stack pointer |
| reqImm | input | 9 | Signed immediate, in granules |
| reqMode | input | 2 | Addressing-mode code |
| reqBaseIsSp | input | 1 | Base taken from the stack pointer |
| reqSrcIsSp | input | 1 | Tag source taken from the stack pointer |
| memValid | output | 1 | Memory write request |
| memReady | input | 1 | Memory accepts the write |
| memAddr | output | 64 | Granule address |
| memDataWr | output | 1 | Data-write strobe |
| memData | output | 128 | Data to write (all zero) |
| memTagWr | output | 1 | Tag-write strobe |
| memTag | output | 4 | Allocation tag to write |
| doneValid | output | 1 | Completion pulse |
| doneFault | output | 1 | Request faulted |
| doneFaultCode | output | 2 | 00 none, 01 stack-pointer alignment, 10 granule alignment |
| wbValid | output | 1 | Base writeback valid |
| wbToSp | output | 1 | Writeback targets the stack pointer |
| wbValue | output | 64 | Updated base value |

## Verification
The bench uses the default parameters: a 64-bit address, a 16-byte granule, a 9-bit immediate and the tag at bits 59:56. With a full-width address, a base near 2^64 combined with a positive offset reaches the wraparound of the writeback sum. Immediates of 0x0FF and 0x100 reach both ends of the offset range. Variable memory-ready delays show that each write is held and that the data write always comes before the tag write.

// File: rtl/tzs_pkg.sv
package tzs_pkg;
  typedef enum logic [1:0] {
    MODE_NONE   = 2'b00,
    MODE_POST   = 2'b01,
    MODE_OFFSET = 2'b10,
    MODE_PRE    = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_SP    = 2'b01,
    FLT_GRAN  = 2'b10
  } fault_e;

  typedef struct packed {
    logic capture;
    logic dataPhase;
    logic tagPhase;
  } dpStrobe_t;
endpackage

// File: rtl/tzs_datapath.sv
module tzs_datapath import tzs_pkg::*; #(
  parameter int ADDR_W    = 64,
  parameter int IMM_W     = 9,
  parameter int GRAN_LOG2 = 4,
  parameter int TAG_W     = 4,
  parameter int TAG_LSB   = 56
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobe_t                   strobe,
  input  logic [ADDR_W-1:0]           reqGpBase,
  input  logic [ADDR_W-1:0]           reqGpSrc,
  input  logic [ADDR_W-1:0]           reqSp,
  input  logic [IMM_W-1:0]            reqImm,
  input  logic [1:0]                  reqMode,
  input  logic                        reqBaseIsSp,
  input  logic                        reqSrcIsSp,
  output logic [ADDR_W-1:0]           memAddr,
  output logic [(8<<GRAN_LOG2)-1:0]   memData,
  output logic [TAG_W-1:0]            memTag,
  output fault_e                      faultCode,
  output logic                        writeback,
  output logic                        baseWasSp,
  output logic [ADDR_W-1:0]           wbValue
);
  localparam int DATA_W = 8 << GRAN_LOG2;

  logic [ADDR_W-1:0] baseQ;
  logic [TAG_W-1:0]  tagQ;
  logic [IMM_W-1:0]  immQ;
  mode_e             modeQ;
  logic              baseIsSpQ;
  logic [ADDR_W-1:0] srcSel;
  logic [ADDR_W-1:0] offsetExt;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] accessAddr;
  logic              spMisaligned;
  logic              granMisaligned;

  assign srcSel = reqSrcIsSp ? reqSp : reqGpSrc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ     <= '0;
      tagQ      <= '0;
      immQ      <= '0;
      modeQ     <= MODE_NONE;
      baseIsSpQ <= 1'b0;
    end else if (strobe.capture) begin
      baseQ     <= reqBaseIsSp ? reqSp : reqGpBase;
      tagQ      <= srcSel[TAG_LSB +: TAG_W];
      immQ      <= reqImm;
      modeQ     <= mode_e'(reqMode);
      baseIsSpQ <= reqBaseIsSp;
    end
  end

  assign offsetExt  = {{(ADDR_W-IMM_W){immQ[IMM_W-1]}}, immQ};
  assign offset     = offsetExt << GRAN_LOG2;
  assign sum        = baseQ + offset;
  assign accessAddr = (modeQ == MODE_POST) ? baseQ : sum;

  assign spMisaligned   = baseIsSpQ && (baseQ[GRAN_LOG2-1:0] != '0);
  assign granMisaligned = accessAddr[GRAN_LOG2-1:0] != '0;

  always_comb begin
    if (spMisaligned)        faultCode = FLT_SP;
    else if (granMisaligned) faultCode = FLT_GRAN;
    else                     faultCode = FLT_NONE;
  end

  assign writeback = (modeQ == MODE_POST) || (modeQ == MODE_PRE);
  assign baseWasSp = baseIsSpQ;
  assign wbValue   = sum;
  assign memAddr   = accessAddr;
  assign memData   = {DATA_W{1'b0}};
  assign memTag    = strobe.tagPhase ? tagQ : '0;

  // R5: a write is only issued on a granule-aligned address
  p_addr_aligned_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dataPhase || strobe.tagPhase) |-> (memAddr[GRAN_LOG2-1:0] == '0));
  // R6: tag and data addresses match across the two phases
  p_same_addr_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tagPhase |-> $stable(memAddr));
endmodule

// File: rtl/tzs_control.sv
module tzs_control import tzs_pkg::*; (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  input  logic      memReady,
  output logic      memValid,
  output logic      memDataWr,
  output logic      memTagWr,
  input  fault_e    faultCode,
  input  logic      writeback,
  output dpStrobe_t strobe,
  output logic      doneValid,
  output logic      wbValid
);
  typedef enum logic [2:0] {S_IDLE, S_EVAL, S_DATA, S_TAG, S_DONE} state_e;
  state_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE: if (reqValid) stateNext = S_EVAL;
      S_EVAL: stateNext = (faultCode != FLT_NONE) ? S_DONE : S_DATA;
      S_DATA: if (memReady) stateNext = S_TAG;
      S_TAG:  if (memReady) stateNext = S_DONE;
      S_DONE: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  assign reqReady         = (state == S_IDLE);
  assign strobe.capture   = reqReady && reqValid;
  assign strobe.dataPhase = (state == S_DATA);
  assign strobe.tagPhase  = (state == S_TAG);
  assign memDataWr        = strobe.dataPhase;
  assign memTagWr         = strobe.tagPhase;
  assign memValid         = memDataWr || memTagWr;
  assign doneValid        = (state == S_DONE);
  assign wbValid          = doneValid && writeback && (faultCode == FLT_NONE);

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(memDataWr && memTagWr));
  p_data_before_tag_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memTagWr) |-> $past(memDataWr && memReady));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> memValid);
  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
  p_fault_no_mem_r5: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && faultCode != FLT_NONE) |-> !$past(memValid));
endmodule

// File: rtl/tag_zero_store.sv
module tag_zero_store import tzs_pkg::*; #(
  parameter int ADDR_W    = 64,
  parameter int IMM_W     = 9,
  parameter int GRAN_LOG2 = 4,
  parameter int TAG_W     = 4,
  parameter int TAG_LSB   = 56
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  output logic                      reqReady,
  input  logic [ADDR_W-1:0]         reqGpBase,
  input  logic [ADDR_W-1:0]         reqGpSrc,
  input  logic [ADDR_W-1:0]         reqSp,
  input  logic [IMM_W-1:0]          reqImm,
  input  logic [1:0]                reqMode,
  input  logic                      reqBaseIsSp,
  input  logic                      reqSrcIsSp,
  output logic                      memValid,
  input  logic                      memReady,
  output logic [ADDR_W-1:0]         memAddr,
  output logic                      memDataWr,
  output logic [(8<<GRAN_LOG2)-1:0] memData,
  output logic                      memTagWr,
  output logic [TAG_W-1:0]          memTag,
  output logic                      doneValid,
  output logic                      doneFault,
  output logic [1:0]                doneFaultCode,
  output logic                      wbValid,
  output logic                      wbToSp,
  output logic [ADDR_W-1:0]         wbValue
);
  dpStrobe_t strobe;
  fault_e    faultCode;
  logic      writeback;
  logic      baseWasSp;

  tzs_datapath #(
    .ADDR_W(ADDR_W), .IMM_W(IMM_W), .GRAN_LOG2(GRAN_LOG2),
    .TAG_W(TAG_W), .TAG_LSB(TAG_LSB)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqGpBase(reqGpBase), .reqGpSrc(reqGpSrc), .reqSp(reqSp),
    .reqImm(reqImm), .reqMode(reqMode),
    .reqBaseIsSp(reqBaseIsSp), .reqSrcIsSp(reqSrcIsSp),
    .memAddr(memAddr), .memData(memData), .memTag(memTag),
    .faultCode(faultCode), .writeback(writeback),
    .baseWasSp(baseWasSp), .wbValue(wbValue)
  );

  tzs_control u_control (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .memReady(memReady), .memValid(memValid),
    .memDataWr(memDataWr), .memTagWr(memTagWr),
    .faultCode(faultCode), .writeback(writeback), .strobe(strobe),
    .doneValid(doneValid), .wbValid(wbValid)
  );

  assign doneFaultCode = doneValid ? faultCode : FLT_NONE;
  assign doneFault     = doneValid && (faultCode != FLT_NONE);
  assign wbToSp        = wbValid && baseWasSp;

  p_fault_wb_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (doneValid && !doneFault));
  p_wbsp_r4: assert property (@(posedge clk) disable iff (!rstN)
    wbToSp |-> wbValid);
endmodule

// File: tb/tag_zero_store_bench.sv
module tag_zero_store_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic         reqValid = 1'b0;
  logic         reqReady;
  logic [63:0]  reqGpBase = '0, reqGpSrc = '0, reqSp = '0;
  logic [8:0]   reqImm = '0;
  logic [1:0]   reqMode = '0;
  logic         reqBaseIsSp = 1'b0, reqSrcIsSp = 1'b0;
  logic         memValid, memReady = 1'b0, memDataWr, memTagWr;
  logic [63:0]  memAddr;
  logic [127:0] memData;
  logic [3:0]   memTag;
  logic         doneValid, doneFault, wbValid, wbToSp;
  logic [1:0]   doneFaultCode;
  logic [63:0]  wbValue;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  tag_zero_store u_tag_zero_store (.*);

  task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Generic runner: drives one request, models the memory, checks all outputs.
  task automatic runOp(input string tag, input logic [63:0] gpBase, input logic [63:0] gpSrc,
                       input logic [63:0] sp, input logic [8:0] imm, input logic [1:0] mode,
                       input logic baseSp, input logic srcSp, input int delay);
    logic [63:0] off, base, src, acc, expWb;
    logic [1:0]  expCode;
    logic        expWbV;
    int nData = 0, nTag = 0, waitCnt = 0, order = 0;
    logic [63:0] dAddr = '0, tAddr = '0;
    logic [127:0] dVal = '1;
    logic [3:0]  tVal = '0;
    logic seenDone = 0, gFault = 0, gWb = 0, gWbSp = 0;
    logic [1:0] gCode = '0;
    logic [63:0] gWbVal = '0;
    off   = {{55{imm[8]}}, imm} << 4;
    base  = baseSp ? sp : gpBase;
    src   = srcSp ? sp : gpSrc;
    acc   = (mode == 2'b01) ? base : base + off;
    expWb = base + off;
    if (baseSp && sp[3:0] != 0)  expCode = 2'b01;
    else if (acc[3:0] != 0)       expCode = 2'b10;
    else                          expCode = 2'b00;
    expWbV = mode[0] && (expCode == 2'b00);

    @(negedge clk);
    reqGpBase = gpBase; reqGpSrc = gpSrc; reqSp = sp; reqImm = imm;
    reqMode = mode; reqBaseIsSp = baseSp; reqSrcIsSp = srcSp; reqValid = 1'b1;
    chk(reqReady, {tag, " R8 ready when idle"}, reqReady, 1);
    @(negedge clk);
    reqValid = 1'b0; reqGpBase = '1; reqSp = '1; reqGpSrc = '0;
    chk(!reqReady, {tag, " R8 busy after accept"}, reqReady, 0);
    for (int i = 0; i < 60 && !seenDone; i++) begin
      if (doneValid) begin
        seenDone = 1; gFault = doneFault; gCode = doneFaultCode;
        gWb = wbValid; gWbSp = wbToSp; gWbVal = wbValue;
      end else begin
        if (memValid) begin
          memReady = (waitCnt >= delay);
          if (memReady) begin
            waitCnt = 0;
            if (memDataWr) begin nData++; dAddr = memAddr; dVal = memData; if (nTag == 0) order = 1; end
            if (memTagWr)  begin nTag++;  tAddr = memAddr; tVal = memTag; end
          end else waitCnt++;
        end else memReady = 1'b0;
        @(negedge clk);
      end
    end
    memReady = 1'b0;
    chk(seenDone, {tag, " R8 completion seen"}, seenDone, 1);
    @(negedge clk);
    chk(!doneValid, {tag, " R8 single-cycle done"}, doneValid, 0);
    chk(gCode == expCode, {tag, " R4 R5 fault code"}, gCode, expCode);
    chk(gFault == (expCode != 0), {tag, " R8 fault flag"}, gFault, expCode != 0);
    chk(gWb == expWbV, {tag, " R2 R9 writeback valid"}, gWb, expWbV);
    if (expWbV) begin
      chk(gWbVal == expWb, {tag, " R1 writeback value"}, gWbVal, expWb);
      chk(gWbSp == baseSp, {tag, " R4 writeback to sp"}, gWbSp, baseSp);
    end
    if (expCode != 0) begin
      chk(nData == 0 && nTag == 0, {tag, " R5 no write on fault"}, nData + nTag, 0);
    end else begin
      chk(nData == 1 && nTag == 1 && order == 1, {tag, " R6 one data then one tag"},
          {nData[7:0], nTag[7:0], order[7:0]}, 24'h010101);
      chk(dAddr == acc, {tag, " R3 access address"}, dAddr, acc);
      chk(tAddr == acc, {tag, " R6 tag address"}, tAddr, acc);
      chk(dVal == '0, {tag, " R6 zero data"}, dVal, 0);
      chk(tVal == src[59:56], {tag, " R7 tag value"}, tVal, src[59:56]);
    end
  endtask

  task automatic testReset();
    chk(reqReady === 1'b1, "R8 reset ready", reqReady, 1);
    chk(memValid === 1'b0, "R6 reset no write", memValid, 0);
    chk(doneValid === 1'b0 && wbValid === 1'b0, "R9 reset no done", {doneValid, wbValid}, 0);
  endtask

  task automatic testModes();
    runOp("offset", 64'h1000, 64'h0A00_0000_0000_0000, 64'h0, 9'h003, 2'b10, 0, 0, 0);
    runOp("pre",    64'h2000, 64'h0500_0000_0000_0000, 64'h0, 9'h1FF, 2'b11, 0, 0, 1);
    runOp("post",   64'h3000, 64'h0C00_0000_0000_0000, 64'h0, 9'h010, 2'b01, 0, 0, 2);
    runOp("mode00", 64'h4000, 64'h0100_0000_0000_0000, 64'h0, 9'h005, 2'b00, 0, 0, 0);
  endtask

  task automatic testStackPointer();
    runOp("spbase",  64'h8, 64'h0300_0000_0000_0000, 64'h7FF0, 9'h002, 2'b11, 1, 0, 0);
    runOp("spsrc",   64'h5000, 64'h0, 64'hF6FF_0000_0000_0000, 9'h000, 2'b10, 0, 1, 1);
    runOp("spfault", 64'h5000, 64'h0, 64'h7FF8, 9'h001, 2'b11, 1, 0, 0);
  endtask

  task automatic testGranuleFault();
    runOp("granpre",  64'h6004, 64'h0, 64'h0, 9'h001, 2'b11, 0, 0, 0);
    runOp("granpost", 64'h600C, 64'h0, 64'h0, 9'h001, 2'b01, 0, 0, 0);
  endtask

  task automatic testEdges();
    runOp("wrap",   64'hFFFF_FFFF_FFFF_FF00, 64'h0F00_0000_0000_0000, 64'h0, 9'h0FF, 2'b01, 0, 0, 3);
    runOp("maxneg", 64'h10000, 64'h0200_0000_0000_0000, 64'h0, 9'h100, 2'b11, 0, 0, 0);
    runOp("stall",  64'h20, 64'h0900_0000_0000_0000, 64'h0, 9'h0FF, 2'b11, 0, 0, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testModes();
    testStackPointer();
    testGranuleFault();
    testEdges();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule